// File: doc/BRIEF.md
# Five-Bit Bidirectional Port with Direction Control

This block is a five-bit I/O port for a small microcontroller, sitting on its internal register bus. Each bit has an output latch and a direction bit. A direction bit of 1 makes the pin an input, and 0 makes it drive. Software reads the pins through a two-stage synchronizer, not the output latches. The direction register can be read back directly.

Bit 1 carries a receive-only serial line, so its direction bit stays at 1 at all times. Bit 4 has a different pad. It can only pull its pin low, and when a comparator routing code is written to a small mode register, the comparator result decides the pull instead of the latch. The synchronized level of bit 4 is also brought out as the timer's external clock.

The block has two reset inputs. Power-on reset sets every register to a known state. The other reset leaves bit 4's latch as it was.

Top module: `gpio_tris_port`

## Requirements
- R1: A read of the data address (05h) or the direction address (85h) returns 0 in bits 7..5. A read of any address other than 05h, 85h and 1Fh returns 00h.
- R2: A write lands on the clock edge that samples `bus_we`. For bits 0, 2 and 3, `pad_out` follows the output latch and `pad_oe` is the inverse of the direction bit.
- R3: A read of 05h returns the pin levels `pad_in[4:0]` through two flip-flops, so a pin change appears two edges later. The read does not show the latch contents.
- R4: A read of 85h returns the direction latch in bits 4..0. Bit 1 always reads 1 whatever was written, and `pad_oe[1]` is never asserted.
- R5: Bit 4 is low-side only. `pad_out[4]` is always 0. `pad_oe[4]` is 1 only when direction bit 4 is 0 and the selected source value is 0.
- R6: Bits 2..0 written to address 1Fh form a mode field. When it equals 3'b110, `cmp_out` is the source value for bit 4. Any other value selects output latch bit 4. A read of 1Fh returns the mode in bits 2..0 and 0 above.
- R7: `tmr_clk_in` equals synchronized pin bit 4, with the same two-edge latency as a read.
- R8: Power-on reset (`rst_por`, synchronous, with priority) sets the direction bits to 1 1111, clears all five latch bits, clears the mode and clears the synchronizer.
- R9: The other reset (`rst_other`, synchronous) sets the direction bits to 1 1111, clears latch bits 3..0 and the mode, and keeps latch bit 4 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_por | input | 1 | Power-on reset, active high, synchronous |
| rst_other | input | 1 | Any other reset, active high, synchronous |
| bus_addr | input | 8 | Register address |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| pad_in | input | 5 | Pin levels from the pads |
| pad_out | output | 5 | Value driven to each pad |
| pad_oe | output | 5 | Drive enable for each pad |
| cmp_out | input | 1 | Comparator result for bit 4 routing |
| tmr_clk_in | output | 1 | Synchronized bit 4 level for the timer clock |

## Verification
Register writes, the pad drive controls and reset effects are due one edge after the cycle that samples them. The bench therefore samples these 1 ns after that edge. Pin reads and the timer clock output are due two edges after `pad_in` changes. The bench checks the read once after the first edge and confirms it still shows the old value, then checks again after the second edge. Reads and the bit 4 comparator path are combinational, so the bench samples them 1 ns after it drives the address or `cmp_out`.

// File: rtl/gpio_tris_port.sv
module gpio_tris_port #(
  parameter logic [7:0] DATA_ADDR = 8'h05,
  parameter logic [7:0] DIR_ADDR  = 8'h85,
  parameter logic [7:0] CMP_ADDR  = 8'h1F,
  parameter logic [2:0] CMP_ROUTE = 3'b110
) (
  input  logic       clk,
  input  logic       rst_por,
  input  logic       rst_other,
  input  logic [7:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [4:0] pad_in,
  output logic [4:0] pad_out,
  output logic [4:0] pad_oe,
  input  logic       cmp_out,
  output logic       tmr_clk_in
);

  logic [4:0] lat_q, tris_q, sync1_q, sync2_q;
  logic [2:0] mode_q;
  logic       src4;
  logic       unused_wdata;

  wire wr_data = bus_we && (bus_addr == DATA_ADDR);
  wire wr_dir  = bus_we && (bus_addr == DIR_ADDR);
  wire wr_cmp  = bus_we && (bus_addr == CMP_ADDR);
  wire any_rst = rst_por || rst_other;

  assign unused_wdata = ^bus_wdata[7:5];

  always_ff @(posedge clk) begin
    if (rst_por) begin
      lat_q  <= '0;
      tris_q <= 5'h1F;
      mode_q <= '0;
    end else if (rst_other) begin
      lat_q[3:0] <= '0;
      tris_q     <= 5'h1F;
      mode_q     <= '0;
    end else begin
      if (wr_data) lat_q  <= bus_wdata[4:0];
      if (wr_dir)  tris_q <= {bus_wdata[4:2], 1'b1, bus_wdata[0]};
      if (wr_cmp)  mode_q <= bus_wdata[2:0];
    end
  end

  always_ff @(posedge clk) begin
    if (any_rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_in;
      sync2_q <= sync1_q;
    end
  end

  assign src4       = (mode_q == CMP_ROUTE) ? cmp_out : lat_q[4];
  assign pad_out    = {1'b0, lat_q[3:0]};
  assign pad_oe     = {~tris_q[4] & ~src4, ~tris_q[3], ~tris_q[2], 1'b0, ~tris_q[0]};
  assign tmr_clk_in = sync2_q[4];

  always_comb begin
    case (bus_addr)
      DATA_ADDR: bus_rdata = {3'b000, sync2_q};
      DIR_ADDR:  bus_rdata = {3'b000, tris_q};
      CMP_ADDR:  bus_rdata = {5'b00000, mode_q};
      default:   bus_rdata = 8'h00;
    endcase
  end

  p_hidden_bits_r1: assert property (@(posedge clk) disable iff (any_rst)
    ((bus_addr == DATA_ADDR) || (bus_addr == DIR_ADDR)) |-> (bus_rdata[7:5] == 3'b000));

  p_rx_dir_set_r4: assert property (@(posedge clk) disable iff (any_rst)
    (bus_addr == DIR_ADDR) |-> bus_rdata[1]);

  p_release_on_one_r5: assert property (@(posedge clk) disable iff (any_rst)
    (wr_data && bus_wdata[4] && (mode_q != CMP_ROUTE)) |=> !pad_oe[4]);

  p_cmp_release_r6: assert property (@(posedge clk) disable iff (any_rst)
    ((mode_q == CMP_ROUTE) && cmp_out) |-> !pad_oe[4]);

  p_por_load_r8: assert property (@(posedge clk)
    rst_por |=> ((tris_q == 5'h1F) && (lat_q == 5'h00) && (mode_q == 3'b000)));

  p_keep_bit4_r9: assert property (@(posedge clk)
    (rst_other && !rst_por) |=> ((lat_q[4] == $past(lat_q[4])) && (lat_q[3:0] == 4'h0) && (tris_q == 5'h1F)));

endmodule

// File: tb/gpio_tris_port_test.sv
module gpio_tris_port_test;
  logic       clk = 1'b0;
  logic       rst_por = 1'b1, rst_other = 1'b0;
  logic [7:0] bus_addr = 8'h00, bus_wdata = 8'h00;
  logic       bus_we = 1'b0;
  logic [7:0] bus_rdata;
  logic [4:0] pad_in = 5'h00, pad_out, pad_oe;
  logic       cmp_out = 1'b0, tmr_clk_in;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  gpio_tris_port uut (
    .clk(clk), .rst_por(rst_por), .rst_other(rst_other),
    .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .cmp_out(cmp_out), .tmr_clk_in(tmr_clk_in));

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'h85, d); check("R8 dir after POR", d, 8'h1F);
    rd(8'h05, d); check("R8 pins after POR", d, 8'h00);
    rd(8'h1F, d); check("R8 mode after POR", d, 8'h00);
    check("R8 no drive after POR", {3'b0, pad_oe}, 8'h00);
    check("R8 latch after POR", {3'b0, pad_out}, 8'h00);
  endtask

  task automatic t_outputs();
    logic [7:0] d;
    wr(8'h85, 8'h00);
    rd(8'h85, d); check("R4 dir bit1 forced", d, 8'h02);
    wr(8'h05, 8'h0D);
    check("R2 pad_out low bits", {3'b0, pad_out}, 8'h0D);
    check("R2 R4 oe pattern", {3'b0, pad_oe}, 8'h1D);
    wr(8'h85, 8'hF3);
    rd(8'h85, d); check("R1 R4 dir readback", d, 8'h13);
    check("R2 oe follows dir", {3'b0, pad_oe}, 8'h0C);
    wr(8'h05, 8'h1F);
    check("R5 bit4 never drives high", {7'b0, pad_out[4]}, 8'h00);
  endtask

  task automatic t_pins();
    logic [7:0] d;
    wr(8'h05, 8'h00);
    pad_in = 5'h15;
    tick();
    rd(8'h05, d); check("R3 not yet after one edge", d, 8'h00);
    check("R7 timer clk not yet", {7'b0, tmr_clk_in}, 8'h00);
    tick();
    rd(8'h05, d); check("R3 pins after two edges", d, 8'h15);
    check("R7 timer clk follows bit4", {7'b0, tmr_clk_in}, 8'h01);
    pad_in = 5'h0A; tick(); tick();
    rd(8'h05, d); check("R3 second pattern", d, 8'h0A);
    check("R7 timer clk low", {7'b0, tmr_clk_in}, 8'h00);
    rd(8'h40, d); check("R1 unmapped address", d, 8'h00);
  endtask

  task automatic t_open_drain();
    wr(8'h85, 8'h00);
    wr(8'h05, 8'h00);
    check("R5 pull low when latch 0", {7'b0, pad_oe[4]}, 8'h01);
    wr(8'h05, 8'h10);
    check("R5 released when latch 1", {7'b0, pad_oe[4]}, 8'h00);
    wr(8'h05, 8'h00);
    wr(8'h85, 8'h10);
    check("R5 released when input", {7'b0, pad_oe[4]}, 8'h00);
  endtask

  task automatic t_comparator();
    logic [7:0] d;
    wr(8'h85, 8'h00);
    wr(8'h05, 8'h10);
    wr(8'h1F, 8'hF6);
    rd(8'h1F, d); check("R6 mode readback", d, 8'h06);
    cmp_out = 1'b0; #1;
    check("R6 comparator 0 pulls low", {7'b0, pad_oe[4]}, 8'h01);
    cmp_out = 1'b1; #1;
    check("R6 comparator 1 releases", {7'b0, pad_oe[4]}, 8'h00);
    wr(8'h05, 8'h00);
    check("R6 latch ignored in route", {7'b0, pad_oe[4]}, 8'h00);
    wr(8'h1F, 8'h05);
    check("R6 other mode uses latch", {7'b0, pad_oe[4]}, 8'h01);
    cmp_out = 1'b0;
  endtask

  task automatic t_resets();
    logic [7:0] d;
    wr(8'h05, 8'h1F);
    wr(8'h1F, 8'h06);
    rst_other = 1'b1; tick(); rst_other = 1'b0;
    rd(8'h85, d); check("R9 dir after other reset", d, 8'h1F);
    rd(8'h1F, d); check("R9 mode cleared", d, 8'h00);
    check("R9 low latch cleared", {3'b0, pad_out}, 8'h00);
    wr(8'h85, 8'h00);
    check("R9 bit4 latch kept", {7'b0, pad_oe[4]}, 8'h00);
    rst_por = 1'b1; tick(); rst_por = 1'b0;
    wr(8'h85, 8'h00);
    check("R8 bit4 latch cleared by POR", {7'b0, pad_oe[4]}, 8'h01);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(); tick(); tick();
    rst_por = 1'b0;
    t_reset();
    t_outputs();
    t_pins();
    t_open_drain();
    t_comparator();
    t_resets();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule